// File: doc/BRIEF.md
# Pulse-Swallow Programmable Feedback Divider

This block divides a fast input clock by a programmable ratio of M·N + A and emits one comparison pulse per completed division cycle. M is the base modulus of a dual-modulus prescaler, selectable between 64 and 128. A swallow count A makes the first A prescaler periods of every cycle one clock longer (M+1). After those periods the prescaler runs at M until a main counter has seen N prescaler periods. The prescaler is plain synchronous logic that runs on the input clock.

The divider setting (modulus select, N and A) is sampled from the input ports only at the clock edge that closes a cycle. A cycle in progress therefore always completes with the setting it started with. A setting that breaks the legality rule (N below 5, or A not smaller than N) is not adopted. The divider keeps its last legal setting and raises a sticky error flag. After reset the divider runs with N = 5, A = 0 and modulus 64/65 until its first cycle boundary.

Top module: `pswallow_div`

## Requirements
- R1: One cycle lasts exactly M·N + A input clocks, measured from one fp pulse to the next. M is 64 when `sel_small` = 1 and 128 when `sel_small` = 0.
- R2: `mod_ctl` is high while the prescaler divides by M+1. This covers the first A prescaler periods of a cycle, A·(M+1) clocks per cycle in total. It is low for the rest of the cycle, including the clock on which fp is high.
- R3: With A = 0, `mod_ctl` stays low for the whole cycle and the cycle lasts M·N clocks.
- R4: `fp` is high for exactly one input clock: the last clock of each cycle.
- R5: `sel_small`, `n_word` and `a_word` are sampled only at the rising edge that follows a clock with fp high. A change made in the middle of a cycle does not alter that cycle's length, and it governs the following cycle.
- R6: At a cycle boundary, a setting with `n_word` < 5 or `a_word` >= `n_word` is rejected. The next cycle repeats the previous legal setting, and `cfg_err` goes high at that boundary edge.
- R7: Once high, `cfg_err` stays high until reset, even after legal settings are adopted again.
- R8: While `rst_n` is low, `fp`, `mod_ctl` and `cfg_err` are 0 and the active setting is N = 5, A = 0, M = 64. fp first goes high after the 319th rising edge following reset release, and every later cycle lasts 320 clocks until a new setting is adopted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock being divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_small | input | 1 | Prescaler size: 1 selects 64/65, 0 selects 128/129 |
| n_word | input | 11 | Main counter value N, legal range 5 to 2047 |
| a_word | input | 7 | Swallow count A, legal range 0 to N-1 |
| fp | output | 1 | One-clock comparison pulse at the end of each cycle |
| mod_ctl | output | 1 | Modulus control: high while the prescaler divides by M+1 |
| cfg_err | output | 1 | Sticky flag: an illegal setting was offered at a boundary |

## Verification
The hardest situation to reach from the ports is a setting change that lands in the middle of a cycle. Checking it needs the length of the interrupted cycle and the length of the one after it. The bench first locks onto an fp pulse and then waits a fixed number of clocks inside the known 320-clock cycle. It changes the inputs at that point and adds the waited clocks to the remaining count, so the interrupted cycle must still total 320. The next cycle must follow the new setting. Rejection of an illegal setting is reached the same way: the illegal words are held across a boundary, and the bench confirms that the following cycle keeps the old length.

// File: rtl/psd_pkg.sv
package psd_pkg;
   // Prescaler size selection
   typedef enum logic {
      PSEL_LARGE = 1'b0,
      PSEL_SMALL = 1'b1
   } psel_e;
endpackage

// File: rtl/psd_cfg_latch.sv
module psd_cfg_latch
   import psd_pkg::*;
#(
   parameter int N_W   = 11,
   parameter int A_W   = 7,
   parameter int N_MIN = 5,
   parameter int RST_N = 5
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           wrap,
   input  logic           sel_in,
   input  logic [N_W-1:0] n_in,
   input  logic [A_W-1:0] a_in,
   output psel_e          sel_act,
   output psel_e          sel_nxt,
   output logic [N_W-1:0] n_nxt,
   output logic [A_W-1:0] a_nxt,
   output logic           cfg_err
);
   localparam int PAD = N_W - A_W;
   localparam logic [N_W-1:0] N_MIN_V = N_MIN[N_W-1:0];
   localparam logic [N_W-1:0] N_RST_V = RST_N[N_W-1:0];

   logic [N_W-1:0] n_q;
   logic [A_W-1:0] a_q;
   psel_e          sel_q;
   logic           legal;

   assign legal   = (n_in >= N_MIN_V) && ({{PAD{1'b0}}, a_in} < n_in);
   assign sel_act = sel_q;
   assign sel_nxt = legal ? psel_e'(sel_in) : sel_q;
   assign n_nxt   = legal ? n_in : n_q;
   assign a_nxt   = legal ? a_in : a_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         n_q     <= N_RST_V;
         a_q     <= '0;
         sel_q   <= PSEL_SMALL;
         cfg_err <= 1'b0;
      end else if (wrap) begin
         n_q   <= n_nxt;
         a_q   <= a_nxt;
         sel_q <= sel_nxt;
         if (!legal) cfg_err <= 1'b1;
      end
   end

   // R7
   err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |=> cfg_err);
   // R5
   hold_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wrap |=> $stable({sel_q, n_q, a_q}));
   // R6
   active_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (n_q >= N_MIN_V) && ({{PAD{1'b0}}, a_q} < n_q));
endmodule

// File: rtl/psd_prescaler.sv
module psd_prescaler
   import psd_pkg::*;
#(
   parameter int M_SMALL = 64
) (
   input  logic  clk,
   input  logic  rst_n,
   input  psel_e sel,
   input  logic  plus1,
   output logic  pp
);
   localparam int PC_W = $clog2(2 * M_SMALL) + 1;
   localparam logic [PC_W-1:0] LD_S0 = PC_W'(M_SMALL - 1);
   localparam logic [PC_W-1:0] LD_S1 = PC_W'(M_SMALL);
   localparam logic [PC_W-1:0] LD_L0 = PC_W'(2 * M_SMALL - 1);
   localparam logic [PC_W-1:0] LD_L1 = PC_W'(2 * M_SMALL);

   generate
      if (M_SMALL < 4) begin : g_bad_mod
         $error("psd_prescaler: M_SMALL must be at least 4");
      end
   endgenerate

   logic [PC_W-1:0] pc_q;
   logic [PC_W-1:0] ld_val;

   always_comb begin
      if (sel == PSEL_SMALL) ld_val = plus1 ? LD_S1 : LD_S0;
      else                   ld_val = plus1 ? LD_L1 : LD_L0;
   end

   assign pp = (pc_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  pc_q <= LD_S0;
      else if (pp) pc_q <= ld_val;
      else         pc_q <= pc_q - 1'b1;
   end

   // R1
   pp_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pp |=> !pp);
endmodule

// File: rtl/psd_cycle_ctr.sv
module psd_cycle_ctr #(
   parameter int N_W   = 11,
   parameter int A_W   = 7,
   parameter int RST_N = 5
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           pp,
   input  logic [N_W-1:0] n_nxt,
   input  logic [A_W-1:0] a_nxt,
   output logic           wrap,
   output logic           plus1_nxt,
   output logic           mod_ctl
);
   localparam logic [N_W-1:0] N_RST_V = RST_N[N_W-1:0];
   localparam logic [N_W-1:0] N_ONE   = N_W'(1);
   localparam logic [A_W-1:0] A_ONE   = A_W'(1);

   logic [N_W-1:0] nc_q;
   logic [A_W-1:0] sc_q;

   assign wrap      = pp && (nc_q == N_ONE);
   assign mod_ctl   = (sc_q != '0);
   assign plus1_nxt = wrap ? (a_nxt != '0) : (sc_q > A_ONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         nc_q <= N_RST_V;
         sc_q <= '0;
      end else if (pp) begin
         if (wrap) begin
            nc_q <= n_nxt;
            sc_q <= a_nxt;
         end else begin
            nc_q <= nc_q - 1'b1;
            if (sc_q != '0) sc_q <= sc_q - 1'b1;
         end
      end
   end

   // R4
   fp_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> !wrap);
   // R2
   fp_mod_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |-> !mod_ctl);
endmodule

// File: rtl/pswallow_div.sv
module pswallow_div
   import psd_pkg::*;
#(
   parameter int N_W     = 11,
   parameter int A_W     = 7,
   parameter int N_MIN   = 5,
   parameter int M_SMALL = 64,
   parameter int RST_N   = 5
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           sel_small,
   input  logic [N_W-1:0] n_word,
   input  logic [A_W-1:0] a_word,
   output logic           fp,
   output logic           mod_ctl,
   output logic           cfg_err
);
   generate
      if (A_W >= N_W) begin : g_bad_aw
         $error("pswallow_div: A_W must be narrower than N_W");
      end
      if (N_MIN < 2 || RST_N < N_MIN) begin : g_bad_n
         $error("pswallow_div: N_MIN >= 2 and RST_N >= N_MIN required");
      end
   endgenerate

   logic           wrap;
   logic           pp;
   logic           plus1_nxt;
   psel_e          sel_act;
   psel_e          sel_nxt;
   psel_e          sel_pre;
   logic [N_W-1:0] n_nxt;
   logic [A_W-1:0] a_nxt;

   psd_cfg_latch #(.N_W(N_W), .A_W(A_W), .N_MIN(N_MIN), .RST_N(RST_N)) u_cfg (
      .clk     (clk),
      .rst_n   (rst_n),
      .wrap    (wrap),
      .sel_in  (sel_small),
      .n_in    (n_word),
      .a_in    (a_word),
      .sel_act (sel_act),
      .sel_nxt (sel_nxt),
      .n_nxt   (n_nxt),
      .a_nxt   (a_nxt),
      .cfg_err (cfg_err)
   );

   assign sel_pre = wrap ? sel_nxt : sel_act;

   psd_prescaler #(.M_SMALL(M_SMALL)) u_pre (
      .clk   (clk),
      .rst_n (rst_n),
      .sel   (sel_pre),
      .plus1 (plus1_nxt),
      .pp    (pp)
   );

   psd_cycle_ctr #(.N_W(N_W), .A_W(A_W), .RST_N(RST_N)) u_cyc (
      .clk       (clk),
      .rst_n     (rst_n),
      .pp        (pp),
      .n_nxt     (n_nxt),
      .a_nxt     (a_nxt),
      .wrap      (wrap),
      .plus1_nxt (plus1_nxt),
      .mod_ctl   (mod_ctl)
   );

   assign fp = wrap;

   // R8
   reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!fp && !mod_ctl && !cfg_err));
endmodule

// File: tb/sim_pswallow_div.sv
module sim_pswallow_div;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sel_small = 1'b1;
   logic [10:0] n_word = 11'd5;
   logic [6:0]  a_word = 7'd0;
   logic        fp;
   logic        mod_ctl;
   logic        cfg_err;

   int vecs = 0;
   int errs = 0;

   always #10 clk = ~clk;

   pswallow_div u0 (
      .clk(clk), .rst_n(rst_n), .sel_small(sel_small),
      .n_word(n_word), .a_word(a_word),
      .fp(fp), .mod_ctl(mod_ctl), .cfg_err(cfg_err)
   );

   task automatic chk(input string req, input int act, input int exp);
      vecs++;
      if (act != exp) begin
         errs++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; sel_small = 1'b1; n_word = 11'd5; a_word = 7'd0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic wait_fp();
      do @(negedge clk); while (!fp);
   endtask

   // Counts clocks up to and including the next fp sample
   task automatic measure(output int per, output int mch);
      per = 0; mch = 0;
      do begin
         @(negedge clk);
         per++;
         if (mod_ctl) mch++;
      end while (!fp);
   endtask

   task automatic apply(input logic s, input int n, input int a,
                        input int exp_per, input int exp_mc, input string req);
      int per, mch;
      sel_small = s; n_word = 11'(n); a_word = 7'(a);
      wait_fp();
      measure(per, mch);
      chk({req, " period"}, per, exp_per);
      chk({req, " mod_ctl clocks"}, mch, exp_mc);
   endtask

   task automatic t_reset();
      int cnt, per, mch;
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      chk("R8 fp in reset", int'(fp), 0);
      chk("R8 mod_ctl in reset", int'(mod_ctl), 0);
      chk("R8 cfg_err in reset", int'(cfg_err), 0);
      rst_n = 1'b1;
      cnt = 0;
      do begin @(negedge clk); cnt++; end while (!fp);
      chk("R8 first fp edge", cnt, 319);
      measure(per, mch);
      chk("R8 default period", per, 320);
      chk("R3 default mod_ctl clocks", mch, 0);
   endtask

   task automatic t_ratios();
      apply(1'b1, 6, 2, 386, 130, "R1 R2 small N6 A2");
      apply(1'b0, 5, 3, 643, 387, "R1 R2 large N5 A3");
      apply(1'b1, 7, 6, 454, 390, "R2 A=N-1");
      apply(1'b0, 9, 0, 1152, 0, "R3 large A0");
   endtask

   task automatic t_fp_width();
      int hi;
      wait_fp();
      hi = 1;
      @(negedge clk);
      if (fp) hi++;
      chk("R4 fp width", hi, 1);
   endtask

   task automatic t_midcycle();
      int per, mch;
      apply(1'b1, 5, 0, 320, 0, "R5 setup");
      repeat (50) @(negedge clk);
      sel_small = 1'b1; n_word = 11'd6; a_word = 7'd2;
      measure(per, mch);
      chk("R5 interrupted cycle", per + 50, 320);
      measure(per, mch);
      chk("R5 next cycle", per, 386);
      chk("R5 next cycle mod_ctl", mch, 130);
   endtask

   task automatic t_errors();
      int per, mch;
      do_reset();
      chk("R8 cfg_err after reset", int'(cfg_err), 0);
      n_word = 11'd6; a_word = 7'd6;
      wait_fp();
      chk("R6 err before boundary", int'(cfg_err), 0);
      measure(per, mch);
      chk("R6 A>=N keeps period", per, 320);
      chk("R6 A>=N sets err", int'(cfg_err), 1);
      do_reset();
      n_word = 11'd4; a_word = 7'd1;
      wait_fp();
      measure(per, mch);
      chk("R6 N<5 keeps period", per, 320);
      chk("R6 N<5 mod_ctl", mch, 0);
      chk("R6 N<5 sets err", int'(cfg_err), 1);
      apply(1'b1, 8, 1, 513, 65, "R7 legal after error");
      chk("R7 err still set", int'(cfg_err), 1);
   endtask

   initial begin
      t_reset();
      t_ratios();
      t_fp_width();
      t_midcycle();
      t_errors();
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      vecs++;
      errs++;
      $display("FAIL watchdog actual=expired expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
   end
endmodule